// File: doc/BRIEF.md
# CAN Controller Mode and Bus Synchronization Control

This block sits between the CPU register bus and the bit engines of a CAN controller and owns the controller's operating mode. A single byte-wide control register holds the soft-reset, sleep-request and timer-link bits. It also reads back two status bits: sleep acknowledge and bus-synchronized. While soft reset is active, the block holds the controller's flag, interrupt-enable and transmit-control registers at their hard-reset values through a hold output. In the same state it opens a gate that lets CPU writes reach the configuration registers, meaning the bit-timing, mode and acceptance-filter registers.

On the bus side, the block receives the sampled bus level with a one-cycle strobe per bit time. It also receives a bus-off indication from the error logic and a frame-in-progress indication from the frame engines. After soft reset is released, the block counts runs of consecutive recessive bits before it declares the controller synchronized. A controller that is not bus-off needs one run. A bus-off controller needs 128 runs.

The sleep handshake works as follows. A pending request is acknowledged once the bus is synchronized and idle. The acknowledge drops when the CPU withdraws the request, or when a dominant bit is sampled while asleep. Entering soft reset from normal operation emits a one-cycle abort pulse to the transmit and receive engines. The timer-link bit selects the source of the shared timer input.

Top module: `can_mode_ctrl`

## Requirements
- R1: After hard reset the control register reads 0x01. The bit layout is: bit 0 soft reset, bit 1 sleep request, bit 2 sleep acknowledge (read-only), bit 3 timer link, bit 4 synchronized (read-only). Bits 7..5 always read 0.
- R2: A register write with bit 0 = 1 from normal operation enters soft reset. In the cycle after the write, `hold_rst` is 1, `sync_flag` is 0, and `abort_pulse` is 1 for exactly that one cycle. A write with bit 0 = 1 while already in soft reset gives no pulse.
- R3: While in soft reset, bits 1 and 3 stay 0 whatever is written. A write with bit 0 = 0 leaves soft reset and ignores the other written bits, so the register then reads 0x00.
- R4: `hold_rst` is 1 exactly while the soft-reset bit reads 1.
- R5: `cfg_wr_ok` equals `cfg_wr_req` while in soft reset and is 0 otherwise.
- R6: Outside soft reset and not bus-off, `sync_flag` (and bit 4) sets after 11 consecutive strobed recessive bits (`bus_bit` = 1). A strobed dominant bit restarts the count. The flag appears in the cycle after the 11th strobe.
- R7: When `bus_off` is 1, synchronization needs 128 completed runs of 11 recessive bits. A dominant bit restarts only the current run; runs already completed are kept.
- R8: The sleep acknowledge (bit 2) sets one cycle after the request is 1, the controller is synchronized and `frame_busy` is 0. It does not set while `frame_busy` is 1.
- R9: A strobed dominant bit while acknowledged clears both the acknowledge and the sleep request on the next clock.
- R10: A write that clears the sleep request removes the acknowledge one clock after the request reads 0.
- R11: Outside soft reset, a write with bit 0 = 0 loads bits 1 and 3. `timer_sel` follows bit 3: 1 selects the controller's timer signal, 0 selects the port pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| cfg_wr_req | input | 1 | CPU write attempt to a configuration register |
| cfg_wr_ok | output | 1 | Gated configuration write enable |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| bit_strobe | input | 1 | One-cycle pulse per bit time |
| bus_off | input | 1 | Controller is bus-off |
| frame_busy | input | 1 | A frame is in progress |
| sync_flag | output | 1 | Controller synchronized to the bus |
| abort_pulse | output | 1 | Abort request to transmit and receive engines |
| timer_sel | output | 1 | Timer input source select |
| hold_rst | output | 1 | Hold flag, interrupt-enable and transmit-control registers in reset |

## Verification
The assertions check the following on every cycle:
- the abort pulse lasts one cycle;
- synchronization and sleep acknowledge stay off during soft reset, and the writable bits stay at their reset values;
- the configuration gate opens only in soft reset;
- the synchronized flag rises only after a strobed recessive bit;
- the acknowledge falls one clock after the request is withdrawn.

Only the bench scenarios can show the counting behaviour: the exact 11-bit threshold, the restart on a dominant bit, and the 128-run bus-off recovery with an interrupted run. The same holds for the ordering of sleep, wake and re-request. The bench shows these by comparing every cycle against a behavioural reference.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int unsigned CTL_W      = 8;
  localparam int unsigned POS_SRST   = 0;
  localparam int unsigned POS_SLPRQ  = 1;
  localparam int unsigned POS_SLPAK  = 2;
  localparam int unsigned POS_TLINK  = 3;
  localparam int unsigned POS_SYNCH  = 4;
  localparam int unsigned IMPL_BITS  = 5;

  typedef struct packed {
    logic synch;
    logic tlink;
    logic slpak;
    logic slprq;
    logic srst;
  } ctl_view_t;

  localparam logic BUS_RECESSIVE = 1'b1;
endpackage

// File: rtl/can_ctl_reg.sv
module can_ctl_reg
  import can_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             wake_clr,
  output logic             srst_q,
  output logic             slprq_q,
  output logic             tlink_q,
  output logic             enter_srst,
  output logic             abort_q
);
  logic set_srst;
  logic leave_srst;
  logic load_normal;

  assign set_srst    = wr && wdata[POS_SRST];
  assign enter_srst  = set_srst;
  assign leave_srst  = wr && !wdata[POS_SRST] && srst_q;
  assign load_normal = wr && !wdata[POS_SRST] && !srst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= 1'b1;
      slprq_q <= 1'b0;
      tlink_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= set_srst && !srst_q;
      if (set_srst) begin
        srst_q  <= 1'b1;
        slprq_q <= 1'b0;
        tlink_q <= 1'b0;
      end else if (leave_srst) begin
        srst_q  <= 1'b0;
      end else if (load_normal) begin
        slprq_q <= wdata[POS_SLPRQ];
        tlink_q <= wdata[POS_TLINK];
      end else if (wake_clr) begin
        slprq_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_sync_track.sv
module can_sync_track
  import can_mode_pkg::*;
#(
  parameter int unsigned RUN_LEN   = 11,
  parameter int unsigned BOFF_RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bus_bit,
  input  logic strobe,
  input  logic bus_off,
  output logic synch_q
);
  localparam int unsigned RUN_W = (RUN_LEN   > 1) ? $clog2(RUN_LEN)   : 1;
  localparam int unsigned SEQ_W = (BOFF_RUNS > 1) ? $clog2(BOFF_RUNS) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(BOFF_RUNS - 1);

  logic [RUN_W-1:0] run_cnt;
  logic [SEQ_W-1:0] seq_cnt;
  logic             counting;
  logic             run_done;
  logic             recovered;

  assign counting  = !synch_q && strobe;
  assign run_done  = counting && (bus_bit == BUS_RECESSIVE) && (run_cnt == RUN_LAST);
  assign recovered = !bus_off || (seq_cnt == SEQ_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      seq_cnt <= '0;
      synch_q <= 1'b0;
    end else if (clr) begin
      run_cnt <= '0;
      seq_cnt <= '0;
      synch_q <= 1'b0;
    end else if (counting) begin
      if (bus_bit != BUS_RECESSIVE) begin
        run_cnt <= '0;
      end else if (run_done) begin
        run_cnt <= '0;
        if (recovered) begin
          synch_q <= 1'b1;
          seq_cnt <= '0;
        end else begin
          seq_cnt <= seq_cnt + 1'b1;
        end
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_sleep_ctl.sv
module can_sleep_ctl
  import can_mode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic slprq,
  input  logic synch,
  input  logic frame_busy,
  input  logic bus_bit,
  input  logic strobe,
  output logic slpak_q,
  output logic wake
);
  logic may_sleep;

  assign wake      = slpak_q && strobe && (bus_bit != BUS_RECESSIVE);
  assign may_sleep = slprq && synch && !frame_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slpak_q <= 1'b0;
    end else if (clr || wake || !slprq) begin
      slpak_q <= 1'b0;
    end else if (may_sleep) begin
      slpak_q <= 1'b1;
    end
  end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int unsigned RUN_LEN   = 11,
  parameter int unsigned BOFF_RUNS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic [CTL_W-1:0] reg_rdata,
  input  logic             cfg_wr_req,
  output logic             cfg_wr_ok,
  input  logic             bus_bit,
  input  logic             bit_strobe,
  input  logic             bus_off,
  input  logic             frame_busy,
  output logic             sync_flag,
  output logic             abort_pulse,
  output logic             timer_sel,
  output logic             hold_rst
);
  logic      srst_q, slprq_q, tlink_q, enter_srst, abort_q;
  logic      synch_q, slpak_q, wake;
  logic      mode_clr;
  ctl_view_t view;

  assign mode_clr = srst_q || enter_srst;

  can_ctl_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .wdata      (reg_wdata),
    .wake_clr   (wake),
    .srst_q     (srst_q),
    .slprq_q    (slprq_q),
    .tlink_q    (tlink_q),
    .enter_srst (enter_srst),
    .abort_q    (abort_q)
  );

  can_sync_track #(.RUN_LEN(RUN_LEN), .BOFF_RUNS(BOFF_RUNS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (mode_clr),
    .bus_bit (bus_bit),
    .strobe  (bit_strobe),
    .bus_off (bus_off),
    .synch_q (synch_q)
  );

  can_sleep_ctl u_sleep (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (mode_clr),
    .slprq      (slprq_q),
    .synch      (synch_q),
    .frame_busy (frame_busy),
    .bus_bit    (bus_bit),
    .strobe     (bit_strobe),
    .slpak_q    (slpak_q),
    .wake       (wake)
  );

  assign view = '{synch: synch_q, tlink: tlink_q, slpak: slpak_q,
                  slprq: slprq_q, srst: srst_q};

  genvar gi;
  generate
    for (gi = 0; gi < CTL_W; gi++) begin : g_rd
      if (gi < IMPL_BITS) begin : g_impl
        assign reg_rdata[gi] = view[gi];
      end else begin : g_unimpl
        assign reg_rdata[gi] = 1'b0;
      end
    end
  endgenerate

  assign cfg_wr_ok   = cfg_wr_req && srst_q;
  assign hold_rst    = srst_q;
  assign sync_flag   = synch_q;
  assign abort_pulse = abort_q;
  assign timer_sel   = tlink_q;
endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_rdata,
  input logic       cfg_wr_req,
  input logic       cfg_wr_ok,
  input logic       bus_bit,
  input logic       bit_strobe,
  input logic       sync_flag,
  input logic       abort_pulse,
  input logic       hold_rst
);
  // R1
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:5] == 3'b000);
  // R2
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);
  // R2
  abort_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (hold_rst && !sync_flag));
  // R3
  held_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |-> (reg_rdata[3:1] == 3'b000 && !sync_flag));
  // R4
  hold_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst == reg_rdata[0]);
  // R5
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_ok |-> (hold_rst && cfg_wr_req));
  // R6
  sync_after_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_flag) |-> ($past(bit_strobe) && $past(bus_bit)));
  // R8
  ack_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[2] |-> sync_flag);
  // R10
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[1] |=> !reg_rdata[2]);
endmodule

bind can_mode_ctrl can_mode_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rdata   (reg_rdata),
  .cfg_wr_req  (cfg_wr_req),
  .cfg_wr_ok   (cfg_wr_ok),
  .bus_bit     (bus_bit),
  .bit_strobe  (bit_strobe),
  .sync_flag   (sync_flag),
  .abort_pulse (abort_pulse),
  .hold_rst    (hold_rst)
);

// File: tb/test_can_mode_ctrl.sv
`timescale 1ns/1ps
module test_can_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cfg_wr_req = 1'b0;
  logic       cfg_wr_ok;
  logic       bus_bit = 1'b1;
  logic       bit_strobe = 1'b0;
  logic       bus_off = 1'b0;
  logic       frame_busy = 1'b0;
  logic       sync_flag, abort_pulse, timer_sel, hold_rst;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  can_mode_ctrl i_can_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_wr_req(cfg_wr_req), .cfg_wr_ok(cfg_wr_ok),
    .bus_bit(bus_bit), .bit_strobe(bit_strobe), .bus_off(bus_off),
    .frame_busy(frame_busy), .sync_flag(sync_flag), .abort_pulse(abort_pulse),
    .timer_sel(timer_sel), .hold_rst(hold_rst)
  );

  // Behavioural reference model
  bit m_srst, m_rq, m_tl, m_ak, m_sy, m_abort;
  int m_run, m_seq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_srst <= 1; m_rq <= 0; m_tl <= 0; m_ak <= 0; m_sy <= 0;
      m_abort <= 0; m_run <= 0; m_seq <= 0;
    end else begin
      bit clr, wk;
      clr = m_srst || (reg_wr && reg_wdata[0]);
      wk  = m_ak && bit_strobe && !bus_bit;
      m_abort <= reg_wr && reg_wdata[0] && !m_srst;
      if (reg_wr && reg_wdata[0]) begin
        m_srst <= 1; m_rq <= 0; m_tl <= 0;
      end else if (reg_wr && m_srst) begin
        m_srst <= 0;
      end else if (reg_wr) begin
        m_rq <= reg_wdata[1]; m_tl <= reg_wdata[3];
      end else if (wk) begin
        m_rq <= 0;
      end
      if (clr) begin
        m_run <= 0; m_seq <= 0; m_sy <= 0;
      end else if (!m_sy && bit_strobe) begin
        if (!bus_bit) m_run <= 0;
        else if (m_run == 10) begin
          m_run <= 0;
          if (!bus_off || m_seq == 127) begin m_sy <= 1; m_seq <= 0; end
          else m_seq <= m_seq + 1;
        end else m_run <= m_run + 1;
      end
      if (clr || wk || !m_rq) m_ak <= 0;
      else if (m_sy && !frame_busy) m_ak <= 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison, 5 ns after the rising edge
  always begin
    @(posedge clk);
    #5;
    if (rst_n && !done) begin
      chk("R1 R3 R6 R8 rdata model", reg_rdata,
          {3'b000, m_sy, m_tl, m_ak, m_rq, m_srst});
      chk("R2 abort model", abort_pulse, m_abort);
      chk("R4 hold model", hold_rst, m_srst);
      chk("R5 cfg gate model", cfg_wr_ok, cfg_wr_req && m_srst);
      chk("R11 timer_sel model", timer_sel, m_tl);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_strobe = 1'b1; bus_bit = b;
    @(negedge clk); bit_strobe = 1'b0; bus_bit = 1'b1;
  endtask

  task automatic send_run(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset value", reg_rdata, 8'h01);
    chk("R4 hold after reset", hold_rst, 1);
    cfg_wr_req = 1'b1; tick();
    chk("R5 cfg open in soft reset", cfg_wr_ok, 1);

    wr(8'h0B);
    chk("R3 bits held in soft reset", reg_rdata, 8'h01);
    chk("R2 no abort when already in reset", abort_pulse, 0);
    wr(8'h0A);
    chk("R3 exit ignores other bits", reg_rdata, 8'h00);
    chk("R5 cfg closed in normal", cfg_wr_ok, 0);
    cfg_wr_req = 1'b0;

    send_run(10);
    chk("R6 no sync after 10", sync_flag, 0);
    send_bit(1'b0);
    send_run(10);
    chk("R6 dominant restarts run", sync_flag, 0);
    send_bit(1'b1);
    chk("R6 sync after 11", sync_flag, 1);
    chk("R6 sync bit read", reg_rdata[4], 1);

    wr(8'h08);
    chk("R11 timer link", timer_sel, 1);
    chk("R11 rdata", reg_rdata, 8'h18);

    frame_busy = 1'b1;
    wr(8'h0A);
    tick();
    chk("R8 no ack while frame busy", reg_rdata[2], 0);
    frame_busy = 1'b0;
    tick();
    chk("R8 ack when idle", reg_rdata[2], 1);
    send_bit(1'b0);
    chk("R9 wake clears ack", reg_rdata[2], 0);
    chk("R9 wake clears request", reg_rdata[1], 0);

    wr(8'h0A);
    tick();
    chk("R8 ack again", reg_rdata[2], 1);
    wr(8'h08);
    chk("R10 ack lingers one clock", reg_rdata[2], 1);
    tick();
    chk("R10 ack dropped", reg_rdata[2], 0);

    wr(8'h09);
    chk("R2 abort pulse", abort_pulse, 1);
    chk("R2 sync cleared", sync_flag, 0);
    chk("R2 hold set", hold_rst, 1);
    chk("R3 reset value held", reg_rdata, 8'h01);
    tick();
    chk("R2 abort one cycle", abort_pulse, 0);

    bus_off = 1'b1;
    wr(8'h00);
    for (int r = 0; r < 127; r++) begin
      if (r == 5) begin
        send_run(5);
        send_bit(1'b0);
      end
      send_run(11);
    end
    chk("R7 no sync after 127 runs", sync_flag, 0);
    send_run(10);
    chk("R7 no sync mid run 128", sync_flag, 0);
    send_bit(1'b1);
    chk("R7 sync after 128 runs", sync_flag, 1);

    repeat (3) tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule